// File: doc/BRIEF.md
# Cross-Lane Permute Unit

This block rearranges a 64-lane vector of 32-bit values between lanes. It takes a source vector, a second "previous" vector that supplies the default contents of each destination lane, and a 9-bit pattern code. It returns one result vector. The result starts as a copy of the previous vector. Each destination lane that the pattern and the write masks allow is then replaced with the value read from some source lane.

The patterns work at four scopes:
- a free crossbar inside every group of four lanes;
- shifts and rotates by 1 to 15 lanes inside each 16-lane row;
- single-lane shifts and rotates across the whole 64-lane wave;
- lane reversal inside a row or a half-row, and two row broadcasts.

A 4-bit row mask and a 4-bit bank mask limit which lanes are written. A zero-fill flag chooses what a written lane gets when the pattern gives it no valid source lane. An input pulse produces a registered result one cycle later, together with an output strobe and a flag for unknown pattern codes.

Top module: `lane_permute_unit`

## Requirements
- R1: Codes 0x000 to 0x0FF are the quad crossbar. Inside each aligned group of four lanes, destination position k (0..3) takes the source lane in the same group whose position is held in code bits [2k+1:2k].
- R2: Code 0x100+n is a row shift left: destination position p of a 16-lane row reads position p+n of the same row. Code 0x110+n is a row shift right: it reads position p-n. In both, n is 1 to 15. When the read position falls outside the row there is no valid source.
- R3: Code 0x120+n (n = 1 to 15) is a row rotate right: destination position p reads position (p-n) mod 16 of the same row, so every lane has a valid source.
- R4: Codes 0x130, 0x134, 0x138 and 0x13C move the whole wave by one lane. 0x130 is shift left (lane d reads d+1; lane 63 has no valid source). 0x134 is rotate left (d reads (d+1) mod 64). 0x138 is shift right (d reads d-1; lane 0 has no valid source). 0x13C is rotate right (d reads (d-1) mod 64).
- R5: Code 0x140 reverses lane order inside each 16-lane row (position p reads 15-p). Code 0x141 reverses lane order inside each 8-lane half-row (position q of a half-row reads 7-q).
- R6: Code 0x142 writes lane 16r-1 into every lane of row r for r = 1..3. Code 0x143 writes lane 31 into every lane of rows 2 and 3. All other rows have no valid source.
- R7: A lane is written only when row-mask bit (lane/16) and bank-mask bit ((lane mod 16)/4) are both 1. Any other lane returns its previous value.
- R8: A written lane with no valid source returns zero when the zero-fill flag is 1, and returns its previous value when the flag is 0.
- R9: Every code not listed in R1 to R6, for example 0x100, 0x110, 0x120, 0x131 or 0x144 to 0x1FF, sets the illegal flag and returns the previous vector unchanged. Legal codes clear the flag.
- R10: The result, the illegal flag and the output strobe appear on the first clock edge after an input pulse. With no pulse, the strobe is low and the result and flag hold their values. After reset the strobe, the flag and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Starts one permute operation |
| perm_code | input | 9 | Pattern selection code |
| row_en | input | 4 | Row write mask, one bit for each 16-lane row |
| bank_en | input | 4 | Bank write mask, one bit for each 4-lane bank inside a row |
| zero_fill | input | 1 | A written lane with no valid source gets zero when this is 1 |
| src_vec | input | 2048 | Source lanes; lane i is bits [32i+31:32i] |
| prev_vec | input | 2048 | Previous lane values |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Last captured code was unknown |
| res_vec | output | 2048 | Permuted result |

## Verification
The only state in this block is the output register. A wrong decode or a wrong lane index shows up on the very next strobe: a single lane of res_vec holds a value from the wrong source lane, a zero instead of its previous value, or the reverse. Each source lane carries its own index in its value, so a misrouted lane can be traced directly. The bank-mask, row-edge and wave-edge cases are each run with both settings of zero-fill. A register that loads while no operation is pending shows as a result or flag change on an idle cycle. This is checked by changing the inputs while the pulse is low.

// File: rtl/lane_permute_unit.sv
module lane_permute_unit #(
  parameter int LANES = 64,
  parameter int DW    = 32,
  parameter int ROW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [8:0]            perm_code,
  input  logic [LANES/ROW-1:0]  row_en,
  input  logic [ROW/4-1:0]      bank_en,
  input  logic                  zero_fill,
  input  logic [LANES*DW-1:0]   src_vec,
  input  logic [LANES*DW-1:0]   prev_vec,
  output logic                  out_valid,
  output logic                  out_illegal,
  output logic [LANES*DW-1:0]   res_vec
);
  localparam int ROWS = LANES / ROW;
  localparam int HALF = ROW / 2;
  localparam int LW   = $clog2(LANES);

  typedef enum logic [3:0] {
    M_QUAD, M_RSHL, M_RSHR, M_RROR, M_WSHL, M_WROL, M_WSHR, M_WROR,
    M_MIR, M_HMIR, M_B15, M_B31, M_BAD
  } mode_t;

  mode_t mode;
  logic [3:0] amt;
  logic illegal;
  logic [LANES*DW-1:0] nxt;

  assign amt = perm_code[3:0];
  assign illegal = (mode == M_BAD);

  always_comb begin
    mode = M_BAD;
    if (!perm_code[8]) mode = M_QUAD;
    else begin
      case (perm_code[7:4])
        4'h0: mode = (amt != 4'd0) ? M_RSHL : M_BAD;
        4'h1: mode = (amt != 4'd0) ? M_RSHR : M_BAD;
        4'h2: mode = (amt != 4'd0) ? M_RROR : M_BAD;
        4'h3: case (amt)
                4'h0: mode = M_WSHL;
                4'h4: mode = M_WROL;
                4'h8: mode = M_WSHR;
                4'hC: mode = M_WROR;
                default: mode = M_BAD;
              endcase
        4'h4: case (amt)
                4'h0: mode = M_MIR;
                4'h1: mode = M_HMIR;
                4'h2: mode = M_B15;
                4'h3: mode = M_B31;
                default: mode = M_BAD;
              endcase
        default: mode = M_BAD;
      endcase
    end
  end

  // returns {has_source, source_lane}
  function automatic logic [LW:0] pick(input int d, input mode_t m, input int n,
                                       input logic [7:0] q);
    int p, r, s;
    logic ok;
    p = d % ROW;
    r = d / ROW;
    ok = 1'b1;
    s = d;
    case (m)
      M_QUAD: s = d - (d % 4) + int'(q[2*(d%4) +: 2]);
      M_RSHL: begin ok = (p + n) < ROW; s = d + n; end
      M_RSHR: begin ok = p >= n;        s = d - n; end
      M_RROR: s = r*ROW + ((p - n + ROW) % ROW);
      M_WSHL: begin ok = d < LANES-1; s = d + 1; end
      M_WROL: s = (d + 1) % LANES;
      M_WSHR: begin ok = d > 0; s = d - 1; end
      M_WROR: s = (d + LANES - 1) % LANES;
      M_MIR:  s = r*ROW + ROW - 1 - p;
      M_HMIR: s = r*ROW + (p/HALF)*HALF + HALF - 1 - (p % HALF);
      M_B15:  begin ok = r >= 1; s = r*ROW - 1; end
      M_B31:  begin ok = r >= 2; s = 2*ROW - 1; end
      default: ok = 1'b0;
    endcase
    if (!ok) s = d;
    return {ok, LW'(s)};
  endfunction

  always_comb begin
    nxt = prev_vec;
    for (int d = 0; d < LANES; d++) begin
      logic [LW:0] sel;
      logic wr;
      sel = pick(d, mode, int'(amt), perm_code[7:0]);
      wr  = row_en[d / ROW] & bank_en[(d % ROW) / 4];
      if (!illegal && wr) begin
        if (sel[LW])        nxt[d*DW +: DW] = src_vec[int'(sel[LW-1:0])*DW +: DW];
        else if (zero_fill) nxt[d*DW +: DW] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      res_vec     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_vec     <= nxt;
        out_illegal <= illegal;
      end
    end
  end

  p_strobe_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_vec) && $stable(out_illegal)));
  p_unknown_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && perm_code[8] && perm_code[7:0] >= 8'h44) |=> (out_illegal && res_vec == $past(prev_vec)));
  p_masked_rows_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && row_en == '0) |=> (res_vec == $past(prev_vec)));
  p_quad_is_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !perm_code[8]) |=> !out_illegal);
endmodule

// File: tb/lane_permute_unit_tb_top.sv
module lane_permute_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [8:0] perm_code = '0;
  logic [3:0] row_en = 4'hF;
  logic [3:0] bank_en = 4'hF;
  logic zero_fill = 1'b0;
  logic [N*W-1:0] src_vec = '0;
  logic [N*W-1:0] prev_vec = '0;
  logic out_valid, out_illegal;
  logic [N*W-1:0] res_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_permute_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .perm_code(perm_code),
    .row_en(row_en), .bank_en(bank_en), .zero_fill(zero_fill),
    .src_vec(src_vec), .prev_vec(prev_vec),
    .out_valid(out_valid), .out_illegal(out_illegal), .res_vec(res_vec)
  );

  function automatic logic [W-1:0] sv(input int seed, input int i);
    return 32'hA000_0000 + (seed << 16) + i;
  endfunction
  function automatic logic [W-1:0] ov(input int i);
    return 32'h5000_0000 + i;
  endfunction

  // expected lane value built from the requirement text
  function automatic logic [W-1:0] model(input int seed, input int d, input int code,
                                         input logic [3:0] rm, input logic [3:0] bm,
                                         input logic zf);
    int row, pos, src, n;
    bit has;
    row = d / 16; pos = d % 16; n = code & 15; has = 1; src = 0;
    if (code < 'h100) src = 4*(d/4) + ((code >> (2*(d%4))) & 3);
    else if (code >= 'h101 && code <= 'h10F) begin has = (pos + n <= 15); src = 16*row + pos + n; end
    else if (code >= 'h111 && code <= 'h11F) begin has = (pos - n >= 0); src = 16*row + pos - n; end
    else if (code >= 'h121 && code <= 'h12F) src = 16*row + ((pos + 16 - n) & 15);
    else if (code == 'h130) begin has = (d != 63); src = d + 1; end
    else if (code == 'h134) src = (d + 1) & 63;
    else if (code == 'h138) begin has = (d != 0); src = d - 1; end
    else if (code == 'h13C) src = (d + 63) & 63;
    else if (code == 'h140) src = 16*row + (15 - pos);
    else if (code == 'h141) src = 16*row + 8*(pos/8) + (7 - pos%8);
    else if (code == 'h142) begin has = (row > 0); src = 16*row - 1; end
    else if (code == 'h143) begin has = (row > 1); src = 31; end
    else return ov(d);
    if (!(rm[row] && bm[pos/4])) return ov(d);
    if (has) return sv(seed, src);
    return zf ? 32'h0 : ov(d);
  endfunction

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic do_op(input string req, input int seed, input int code,
                       input logic [3:0] rm, input logic [3:0] bm, input logic zf,
                       input logic exp_illegal);
    int bad;
    logic [W-1:0] e, a;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      src_vec[i*W +: W] = sv(seed, i);
      prev_vec[i*W +: W] = ov(i);
    end
    perm_code = 9'(code); row_en = rm; bank_en = bm; zero_fill = zf; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit(req, "strobe", out_valid, 1'b1);
    check_bit(req, "illegal flag", out_illegal, exp_illegal);
    checks++;
    bad = -1;
    for (int i = 0; i < N; i++) begin
      if (bad < 0 && res_vec[i*W +: W] !== model(seed, i, code, rm, bm, zf)) bad = i;
    end
    if (bad >= 0) begin
      errors++;
      e = model(seed, bad, code, rm, bm, zf);
      a = res_vec[bad*W +: W];
      $display("FAIL %s code=%h lane %0d: actual=%h expected=%h", req, code, bad, a, e);
    end
  endtask

  task automatic t_reset;
    check_bit("R10", "reset strobe", out_valid, 1'b0);
    check_bit("R10", "reset flag", out_illegal, 1'b0);
    checks++;
    if (res_vec !== '0) begin
      errors++;
      $display("FAIL R10 reset result: actual=%h expected=0", res_vec[W-1:0]);
    end
  endtask

  task automatic t_quad;      // R1
    do_op("R1", 1, 'h01B, 4'hF, 4'hF, 1'b0, 1'b0);
    do_op("R1", 2, 'h000, 4'hF, 4'hF, 1'b1, 1'b0);
    do_op("R1", 3, 'h091, 4'hF, 4'hF, 1'b0, 1'b0);
  endtask

  task automatic t_row_shift; // R2, R8
    do_op("R2", 4, 'h101, 4'hF, 4'hF, 1'b0, 1'b0);
    do_op("R2", 5, 'h10F, 4'hF, 4'hF, 1'b1, 1'b0);
    do_op("R2", 6, 'h113, 4'hF, 4'hF, 1'b1, 1'b0);
    do_op("R8", 7, 'h11F, 4'hF, 4'hF, 1'b0, 1'b0);
  endtask

  task automatic t_row_rot;   // R3
    do_op("R3", 8, 'h121, 4'hF, 4'hF, 1'b1, 1'b0);
    do_op("R3", 9, 'h12A, 4'hF, 4'hF, 1'b0, 1'b0);
    do_op("R3", 10, 'h12F, 4'hF, 4'hF, 1'b1, 1'b0);
  endtask

  task automatic t_wave;      // R4
    do_op("R4", 11, 'h130, 4'hF, 4'hF, 1'b1, 1'b0);
    do_op("R4", 12, 'h134, 4'hF, 4'hF, 1'b0, 1'b0);
    do_op("R4", 13, 'h138, 4'hF, 4'hF, 1'b0, 1'b0);
    do_op("R4", 14, 'h13C, 4'hF, 4'hF, 1'b1, 1'b0);
  endtask

  task automatic t_mirror;    // R5
    do_op("R5", 15, 'h140, 4'hF, 4'hF, 1'b0, 1'b0);
    do_op("R5", 16, 'h141, 4'hF, 4'hF, 1'b1, 1'b0);
  endtask

  task automatic t_bcast;     // R6
    do_op("R6", 17, 'h142, 4'hF, 4'hF, 1'b0, 1'b0);
    do_op("R6", 18, 'h142, 4'hF, 4'hF, 1'b1, 1'b0);
    do_op("R6", 19, 'h143, 4'hF, 4'hF, 1'b1, 1'b0);
  endtask

  task automatic t_masks;     // R7
    do_op("R7", 20, 'h101, 4'hA, 4'h1, 1'b0, 1'b0);
    do_op("R7", 21, 'h140, 4'h0, 4'hF, 1'b1, 1'b0);
    do_op("R7", 22, 'h10F, 4'h5, 4'h6, 1'b1, 1'b0);
    do_op("R7", 23, 'h143, 4'hF, 4'h8, 1'b1, 1'b0);
  endtask

  task automatic t_illegal;   // R9
    do_op("R9", 24, 'h100, 4'hF, 4'hF, 1'b1, 1'b1);
    do_op("R9", 25, 'h110, 4'hF, 4'hF, 1'b1, 1'b1);
    do_op("R9", 26, 'h120, 4'hF, 4'hF, 1'b0, 1'b1);
    do_op("R9", 27, 'h131, 4'hF, 4'hF, 1'b1, 1'b1);
    do_op("R9", 28, 'h144, 4'hF, 4'hF, 1'b1, 1'b1);
    do_op("R9", 29, 'h1FF, 4'hF, 4'hF, 1'b1, 1'b1);
    do_op("R9", 30, 'h0E4, 4'hF, 4'hF, 1'b1, 1'b0);
  endtask

  task automatic t_timing;    // R10
    logic [N*W-1:0] snap;
    do_op("R10", 31, 'h144, 4'hF, 4'hF, 1'b0, 1'b1);
    snap = res_vec;
    @(negedge clk);
    perm_code = 9'h101; src_vec = ~src_vec; prev_vec = '1;
    @(negedge clk);
    check_bit("R10", "idle strobe", out_valid, 1'b0);
    check_bit("R10", "idle flag hold", out_illegal, 1'b1);
    checks++;
    if (res_vec !== snap) begin
      errors++;
      $display("FAIL R10 idle hold: actual=%h expected=%h", res_vec[W-1:0], snap[W-1:0]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_quad();
    t_row_shift();
    t_row_rot();
    t_wave();
    t_mirror();
    t_bcast();
    t_masks();
    t_illegal();
    t_timing();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule